// File: doc/BRIEF.md
# Tunable Complex Downconverter with Integrate-and-Dump Decimation

This block takes a stream of signed real samples from a converter, one sample per accepted strobe, and turns it into complex baseband pairs. A 44-bit phase accumulator drives a sine table. Its cosine and negated-sine values are multiplied with each sample, which gives an in-phase product and a quadrature product. Each path then feeds a boxcar integrate-and-dump stage. That stage sums a programmable number of consecutive products and emits one result per block of samples. The boxcar acts as both the low-pass filter and the integer decimator.

Each channel instance owns its own tuning word, so every channel is tuned independently. The tuning word may change on any sample without disturbing the running phase. A rate-mode input sets the lowest decimation ratio the block will accept. A width select packs each result either as two 16-bit components or as two 8-bit components.

The decimation ratio, rate mode and width select are configuration. Hold them steady while a sample is inside the block, which is the two cycles after its strobe.

Top module: `ddc_core`

## Requirements
- R1: While reset is low, and after it is released until the first block completes, `out_valid` is 0 and `out_iq` is 0. The phase accumulator starts at 0 and the block sample count starts at 0.
- R2: Each accepted sample (`in_valid`=1) is mixed using the current 44-bit phase. The phase then advances by the `tune_word` presented with that sample, modulo 2^44. Without a strobe the phase holds. A new tuning word changes only the later increments, so the phase never jumps.
- R3: The LO table index is phase bits [43:38]; the lower 38 bits are dropped. For index k, let t = k mod 32 and p = t·(32−t). Then S(k) = trunc(2047·16·p / (5·1024 − 4·p)), negated when k ≥ 32. The sine value is S(k) and the cosine value is S((k+16) mod 64).
- R4: The in-phase product is sample·cosine. The quadrature product is −(sample·sine). The sample is a signed 10-bit value.
- R5: Each path sums consecutive products. When the count of samples in the current block reaches the effective ratio D, the sum including that sample is emitted and the sum restarts from zero. `out_valid` is high for exactly one cycle, two clock edges after the edge that captured the closing sample.
- R6: The effective ratio is D = max(`dec_factor`, 10) when `rate_hi`=1, and D = max(`dec_factor`, 5) when `rate_hi`=0.
- R7: With `wide_sel`=1, each component is (sum >>> 8), saturated to [−32768, 32767]. `out_iq[31:16]` carries I and `out_iq[15:0]` carries Q.
- R8: With `wide_sel`=0, each 16-bit component v from R7 becomes (v + 128) >>> 8, saturated to [−128, 127]. I goes to `out_iq[15:8]`, Q goes to `out_iq[7:0]`, and `out_iq[31:16]` is 0.
- R9: Between result pulses, `out_iq` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 10 | Signed real input sample |
| tune_word | input | 44 | Phase increment per accepted sample |
| dec_factor | input | 8 | Requested decimation ratio |
| rate_hi | input | 1 | 1 raises the minimum ratio from 5 to 10 |
| wide_sel | input | 1 | 1 selects 16+16 packing, 0 selects 8+8 packing |
| out_valid | output | 1 | One-cycle result strobe |
| out_iq | output | 32 | Packed I/Q result |

## Verification
Two events can fall in the same cycle and must be judged together. The first is the closing sample of a block, where the integrator dumps and restarts. The second is a new sample arriving with a changed tuning word, which must step the phase without a jump. The bench changes the tuning word every few samples, including on block-closing samples and on gapped strobes. A behavioural model keeps its own phase, sums and block count. The bench compares strobe timing and the packed result on every cycle. A wrong restart, a phase jump or a misplaced dump shows up as a mismatch in the following blocks.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Integer sine approximation over one full period of tab_n points.
    function automatic int lo_sine(int idx, int tab_n, int amp);
        int  half;
        int  t;
        int  p;
        longint v;
        half = tab_n / 2;
        t    = idx % half;
        p    = t * (half - t);
        v    = (longint'(amp) * 16 * p) / (5 * half * half - 4 * p);
        return (idx < half) ? int'(v) : -int'(v);
    endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco #(
    parameter int PH_W   = 44,
    parameter int LUT_AW = 6,
    parameter int LO_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic [PH_W-1:0]        tune,
    output logic signed [LO_W-1:0] lo_cos,
    output logic signed [LO_W-1:0] lo_sin
);
    import ddc_pkg::*;

    localparam int TAB_N = 1 << LUT_AW;
    localparam int QTR   = TAB_N / 4;
    localparam int AMP   = (1 << (LO_W - 1)) - 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } nco_st_t;

    nco_st_t st_d, st_q;

    logic signed [LO_W-1:0] sin_tab [TAB_N];
    for (genvar g = 0; g < TAB_N; g++) begin : g_tab
        assign sin_tab[g] = LO_W'(lo_sine(g, TAB_N, AMP));
    end

    logic [LUT_AW-1:0] idx_s, idx_c;

    always_comb begin
        st_d  = st_q;
        idx_s = st_q.phase[PH_W-1 -: LUT_AW];
        idx_c = idx_s + LUT_AW'(QTR);
        if (step) st_d.phase = st_q.phase + tune;
    end

    assign lo_sin = sin_tab[idx_s];
    assign lo_cos = sin_tab[idx_c];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
    parameter int IN_W = 10,
    parameter int LO_W = 12,
    localparam int PROD_W = IN_W + LO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    input  logic signed [LO_W-1:0]   lo_cos,
    input  logic signed [LO_W-1:0]   lo_sin,
    output logic                     mix_vld,
    output logic signed [PROD_W-1:0] mix_i,
    output logic signed [PROD_W-1:0] mix_q
);
    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] pi;
        logic [PROD_W-1:0] pq;
    } mix_st_t;

    mix_st_t st_d, st_q;
    logic signed [PROD_W-1:0] x_ext, c_ext, s_ext;

    always_comb begin
        x_ext    = PROD_W'(in_sample);
        c_ext    = PROD_W'(lo_cos);
        s_ext    = PROD_W'(lo_sin);
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pi = x_ext * c_ext;
            st_d.pq = -(x_ext * s_ext);
        end
    end

    assign mix_vld = st_q.vld;
    assign mix_i   = $signed(st_q.pi);
    assign mix_q   = $signed(st_q.pq);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ddc_decim.sv
module ddc_decim #(
    parameter int PROD_W   = 22,
    parameter int DEC_W    = 8,
    parameter int OUT_W    = 16,
    parameter int NAR_W    = 8,
    parameter int RES_SH   = 8,
    parameter int MIN_FAST = 10,
    parameter int MIN_SLOW = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mix_vld,
    input  logic signed [PROD_W-1:0] mix_i,
    input  logic signed [PROD_W-1:0] mix_q,
    input  logic [DEC_W-1:0]         dec_factor,
    input  logic                     rate_hi,
    input  logic                     wide_sel,
    output logic                     out_valid,
    output logic [2*OUT_W-1:0]       out_iq
);
    localparam int ACC_W = PROD_W + DEC_W;
    localparam int PAD_W = 2 * OUT_W - 2 * NAR_W;
    localparam int NSH   = OUT_W - NAR_W;
    localparam logic signed [ACC_W-1:0] W_MAX = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] W_MIN = -W_MAX - 1;
    localparam logic signed [OUT_W:0]   N_MAX = (OUT_W+1)'((1 << (NAR_W - 1)) - 1);
    localparam logic signed [OUT_W:0]   N_MIN = -N_MAX - 1;
    localparam logic signed [OUT_W:0]   RND   = (OUT_W+1)'(1 << (NSH - 1));
    localparam logic [DEC_W-1:0] LIM_HI = DEC_W'(MIN_FAST);
    localparam logic [DEC_W-1:0] LIM_LO = DEC_W'(MIN_SLOW);

    typedef struct packed {
        logic [ACC_W-1:0]   acc_i;
        logic [ACC_W-1:0]   acc_q;
        logic [DEC_W-1:0]   cnt;
        logic               ov;
        logic [2*OUT_W-1:0] oiq;
    } dec_st_t;

    dec_st_t st_d, st_q;

    function automatic logic signed [OUT_W-1:0] to_wide(logic signed [ACC_W-1:0] s);
        logic signed [ACC_W-1:0] sh;
        sh = s >>> RES_SH;
        if (sh > W_MAX)      return W_MAX[OUT_W-1:0];
        else if (sh < W_MIN) return W_MIN[OUT_W-1:0];
        else                 return sh[OUT_W-1:0];
    endfunction

    function automatic logic signed [NAR_W-1:0] to_narrow(logic signed [OUT_W-1:0] v);
        logic signed [OUT_W:0] r;
        r = ((OUT_W+1)'(v) + RND) >>> NSH;
        if (r > N_MAX) return N_MAX[NAR_W-1:0];
        else if (r < N_MIN) return N_MIN[NAR_W-1:0];
        else return r[NAR_W-1:0];
    endfunction

    logic [DEC_W-1:0]        lim, eff;
    logic signed [ACC_W-1:0] sum_i, sum_q;
    logic signed [OUT_W-1:0] w_i, w_q;
    logic                    last;

    always_comb begin
        lim   = rate_hi ? LIM_HI : LIM_LO;
        eff   = (dec_factor < lim) ? lim : dec_factor;
        sum_i = $signed(st_q.acc_i) + ACC_W'(mix_i);
        sum_q = $signed(st_q.acc_q) + ACC_W'(mix_q);
        w_i   = to_wide(sum_i);
        w_q   = to_wide(sum_q);
        last  = mix_vld && (st_q.cnt >= eff - 1'b1);
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (mix_vld) begin
            if (last) begin
                st_d.acc_i = '0;
                st_d.acc_q = '0;
                st_d.cnt   = '0;
                st_d.ov    = 1'b1;
                st_d.oiq   = wide_sel ? {w_i, w_q}
                                      : {{PAD_W{1'b0}}, to_narrow(w_i), to_narrow(w_q)};
            end else begin
                st_d.acc_i = sum_i;
                st_d.acc_q = sum_q;
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    assign out_valid = st_q.ov;
    assign out_iq    = st_q.oiq;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ddc_core.sv
module ddc_core #(
    parameter int PH_W   = 44,
    parameter int IN_W   = 10,
    parameter int LO_W   = 12,
    parameter int LUT_AW = 6,
    parameter int DEC_W  = 8,
    parameter int OUT_W  = 16,
    parameter int NAR_W  = 8,
    parameter int RES_SH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic [PH_W-1:0]        tune_word,
    input  logic [DEC_W-1:0]       dec_factor,
    input  logic                   rate_hi,
    input  logic                   wide_sel,
    output logic                   out_valid,
    output logic [2*OUT_W-1:0]     out_iq
);
    localparam int PROD_W = IN_W + LO_W;

    logic signed [LO_W-1:0]   lo_cos, lo_sin;
    logic                     mix_vld;
    logic signed [PROD_W-1:0] mix_i, mix_q;

    ddc_nco #(.PH_W(PH_W), .LUT_AW(LUT_AW), .LO_W(LO_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .tune(tune_word),
        .lo_cos(lo_cos), .lo_sin(lo_sin)
    );

    ddc_mixer #(.IN_W(IN_W), .LO_W(LO_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .lo_cos(lo_cos), .lo_sin(lo_sin),
        .mix_vld(mix_vld), .mix_i(mix_i), .mix_q(mix_q)
    );

    ddc_decim #(.PROD_W(PROD_W), .DEC_W(DEC_W), .OUT_W(OUT_W),
                .NAR_W(NAR_W), .RES_SH(RES_SH)) u_dec (
        .clk(clk), .rst_n(rst_n), .mix_vld(mix_vld), .mix_i(mix_i), .mix_q(mix_q),
        .dec_factor(dec_factor), .rate_hi(rate_hi), .wide_sel(wide_sel),
        .out_valid(out_valid), .out_iq(out_iq)
    );
endmodule

// File: rtl/ddc_core_chk.sv
module ddc_core_chk #(
    parameter int PH_W  = 44,
    parameter int OUT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [PH_W-1:0]    tune_word,
    input logic [PH_W-1:0]    phase,
    input logic               wide_sel,
    input logic               out_valid,
    input logic [2*OUT_W-1:0] out_iq
);
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> phase == $past(phase));

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> phase == PH_W'($past(phase) + $past(tune_word)));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_pulse_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(wide_sel)) |-> out_iq[2*OUT_W-1:OUT_W] == '0);

    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_iq));
endmodule

bind ddc_core ddc_core_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tune_word(tune_word),
    .phase(u_nco.st_q.phase), .wide_sel(wide_sel),
    .out_valid(out_valid), .out_iq(out_iq)
);

// File: tb/ddc_core_test.sv
module ddc_core_test;
    localparam int PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [9:0] in_sample = '0;
    logic [43:0]       tune_word = '0;
    logic [7:0]        dec_factor = 8'd10;
    logic              rate_hi = 1'b1;
    logic              wide_sel = 1'b1;
    logic              out_valid;
    logic [31:0]       out_iq;

    ddc_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .tune_word(tune_word), .dec_factor(dec_factor), .rate_hi(rate_hi),
        .wide_sel(wide_sel), .out_valid(out_valid), .out_iq(out_iq)
    );

    always #(PERIOD/2) clk = ~clk;

    int     n_checks = 0;
    int     n_fail = 0;
    int     edge_n = 0;
    bit     done = 0;
    string  cur_req = "R1";
    int     sintab [64];
    longint m_ph = 0, m_ai = 0, m_aq = 0;
    int     m_cnt = 0;
    int     due_q [$];
    logic [31:0] exp_q [$];
    logic [31:0] last_word = '0;

    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic int sat(longint v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return int'(v);
    endfunction

    task automatic model_sample(int x);
        int idx, eff, wi, wq, ni, nq;
        idx  = int'(m_ph >> 38);
        m_ai += longint'(x) * sintab[(idx + 16) % 64];   // R3 R4
        m_aq += -(longint'(x) * sintab[idx]);
        m_cnt++;
        m_ph = (m_ph + longint'(tune_word)) & ((64'd1 << 44) - 1);  // R2
        eff  = rate_hi ? ((dec_factor < 10) ? 10 : dec_factor)
                       : ((dec_factor < 5) ? 5 : dec_factor);      // R6
        if (m_cnt >= eff) begin
            wi = sat(m_ai >>> 8, -32768, 32767);                   // R7
            wq = sat(m_aq >>> 8, -32768, 32767);
            ni = sat(longint'(wi + 128) >>> 8, -128, 127);         // R8
            nq = sat(longint'(wq + 128) >>> 8, -128, 127);
            due_q.push_back(edge_n + 2);                           // R5
            exp_q.push_back(wide_sel ? {wi[15:0], wq[15:0]}
                                     : {16'h0, ni[7:0], nq[7:0]});
            m_ai = 0; m_aq = 0; m_cnt = 0;
        end
    endtask

    task automatic check_outputs();
        bit          ev;
        logic [31:0] ew;
        ev = (due_q.size() > 0) && (due_q[0] == edge_n);
        ew = ev ? exp_q[0] : last_word;   // R9 holds otherwise
        n_checks++;
        if (out_valid !== ev || out_iq !== ew) begin
            n_fail++;
            $display("FAIL %s edge %0d: valid=%0b iq=%h expected valid=%0b iq=%h",
                     cur_req, edge_n, out_valid, out_iq, ev, ew);
        end
        if (ev) begin
            last_word = ew;
            void'(due_q.pop_front());
            void'(exp_q.pop_front());
        end
    endtask

    task automatic cycle(bit v, int x, logic [43:0] tw);
        @(negedge clk);
        check_outputs();
        in_valid  = v;
        in_sample = 10'(x);
        tune_word = tw;
        if (v) model_sample(x);
    endtask

    task automatic configure(int d, bit hi, bit wide);
        for (int i = 0; i < 3; i++) cycle(1'b0, 0, tune_word);
        dec_factor = 8'(d);
        rate_hi    = hi;
        wide_sel   = wide;
    endtask

    initial begin
        for (int k = 0; k < 64; k++) begin
            int t, p;
            longint v;
            t = k % 32;
            p = t * (32 - t);
            v = (longint'(2047) * 16 * p) / (5 * 1024 - 4 * p);
            sintab[k] = (k < 32) ? int'(v) : -int'(v);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_iq !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b iq=%h expected valid=0 iq=00000000", out_valid, out_iq);
        end
        rst_n = 1'b1;

        // R2 R3 R4 R5 R7: one table step per sample, gapped strobes, wide packing
        cur_req = "R2 R3 R4 R5 R7";
        configure(10, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++)
            cycle((i % 3) != 2, (i * 37) % 1024 - 512, 44'h040_0000_0000);

        // R8: narrow packing with odd tuning word and slower mode
        cur_req = "R8 R5";
        configure(7, 1'b0, 1'b0);
        for (int i = 0; i < 50; i++)
            cycle(1'b1, ((i * 101) % 900) - 450, 44'h123_4567_89AB);

        // R6: ratio below minimum is clamped in each mode
        cur_req = "R6 fast";
        configure(3, 1'b1, 1'b1);
        for (int i = 0; i < 40; i++) cycle(1'b1, 300 - i * 11, 44'h0A0_0000_0001);
        cur_req = "R6 slow";
        configure(2, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) cycle(1'b1, i * 13 - 200, 44'h0A0_0000_0001);

        // R7 R8: full-scale input for saturation in both packings
        cur_req = "R7 saturation";
        configure(40, 1'b1, 1'b1);
        for (int i = 0; i < 80; i++) cycle(1'b1, (i < 40) ? 511 : -512, 44'h000_0100_0000);
        cur_req = "R8 saturation";
        configure(40, 1'b1, 1'b0);
        for (int i = 0; i < 80; i++) cycle(1'b1, (i < 40) ? -512 : 511, 44'h000_0100_0000);

        // R2: tuning word changes every few samples, also on block edges
        cur_req = "R2 retune";
        configure(6, 1'b0, 1'b1);
        for (int i = 0; i < 72; i++)
            cycle((i % 5) != 4, 200 + (i % 7) * 40,
                  44'h011_1111_1111 * 44'((i / 4) % 9 + 1));

        cur_req = "R5 R9 drain";
        for (int i = 0; i < 6; i++) cycle(1'b0, 0, tune_word);
        if (due_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R5: %0d results missing, expected 0", due_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule